// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns stereo sample pairs, queued in a small FIFO, into one serial data line. An external clock generator supplies two single-cycle enables in the system clock domain. `bit_tick` marks each bit slot. `frame_tick` marks the first slot of a frame and is only ever asserted together with `bit_tick`. A frame has 64 slots: the left half is slots 0 to 31 and the right half is slots 32 to 63. Every half carries one sample word of 16, 24 or 32 bits, sent MSB first.

Software or a stream source loads the FIFO through a simple write port. A write with `wr_right` low stores the left word. The next write with `wr_right` high queues the completed pair. Sample bits sit right-aligned in `wr_data`. Three framing styles are available: left-justified, one-slot-delayed (I2S style) and right-justified. The block reports the FIFO level and a full flag, and raises a level interrupt and an underflow interrupt. When the FIFO runs dry at a frame start, whole zero frames are sent, so left/right alignment is never lost.

Top module: `stereo_ser_tx`

## Requirements
- R1: `cfg_wlen` selects the word length: 0 gives 16 bits, 1 gives 24 bits, 2 gives 32 bits, and the reserved code 3 behaves as 32 bits.
- R2: With `cfg_delay`=0 and `cfg_rjust`=0, the MSB of each word occupies the first slot of its half-frame, bits follow MSB first, and the slots after the LSB carry zero.
- R3: With `cfg_delay`=1, the whole frame content moves one slot later. The first bit of the left word sits in slot 1, and the last slot of a pair lands in slot 0 of the following frame.
- R4: With `cfg_rjust`=1 (used with `cfg_delay`=0), the LSB occupies the last slot of its half-frame and the slots before the MSB carry zero.
- R5: The FIFO holds DEPTH (default 8) pairs. A right write queues the last left word with the right word. `fifo_level` counts the queued pairs, and `fifo_full` is high at DEPTH. A right write while the FIFO is full is dropped.
- R6: `irq_level` is high when `fifo_level` <= DEPTH/2 while `cfg_lvl_sel`=0, and only when the FIFO is empty while `cfg_lvl_sel`=1.
- R7: If the FIFO is empty at a frame start while `cfg_en`=1, both words of that frame are zero and `underflow_flag` is set. The flag stays set until `uf_clr` is pulsed.
- R8: `irq_underflow` equals `underflow_flag` gated by `cfg_uf_ie`.
- R9: After an underflow, a newly written pair is sent as a complete frame starting at the next frame start, with no slot offset.
- R10: Clearing `cfg_en` forces `sdata` to 0 from the next clock, drops the pair in progress and keeps the FIFO contents. Setting it again resumes at the next frame start with the next queued pair.
- R11: While `cfg_en`=1, `sdata` changes only on clocks where `bit_tick` is high.
- R12: After reset, `sdata`, `fifo_level`, `fifo_full`, `underflow_flag` and `irq_underflow` are 0, and `irq_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit slot |
| frame_tick | input | 1 | Marks slot 0 of a frame, with bit_tick |
| cfg_en | input | 1 | Transmit enable |
| cfg_wlen | input | 2 | Word length code |
| cfg_delay | input | 1 | One-slot delay of the frame content |
| cfg_rjust | input | 1 | Right-justified placement |
| cfg_lvl_sel | input | 1 | Level interrupt condition: 0 half empty, 1 empty |
| cfg_uf_ie | input | 1 | Underflow interrupt enable |
| wr_en | input | 1 | Sample write strobe |
| wr_right | input | 1 | 0 left word, 1 right word (queues the pair) |
| wr_data | input | 32 | Sample, right-aligned |
| uf_clr | input | 1 | Clears the underflow flag |
| sdata | output | 1 | Serial data |
| fifo_full | output | 1 | FIFO holds DEPTH pairs |
| fifo_level | output | $clog2(DEPTH+1) | Queued pairs |
| irq_level | output | 1 | FIFO level interrupt |
| irq_underflow | output | 1 | Underflow interrupt |
| underflow_flag | output | 1 | Sticky underflow status |

## Verification
The bench builds the block with its default DEPTH of 8 and drives a bit slot on every second clock. At that rate a full frame takes 128 clocks, so filling the FIFO to full, draining it into underflow, and running several framing styles back to back all fit in a short run. The depth of 8 lets the bench test the half-empty threshold on both sides (4 and 5 pairs) and the full boundary directly. Captured frames are compared bit for bit against patterns built from the word length, delay and justification settings.

// File: rtl/stereo_ser_tx_pkg.sv
package stereo_ser_tx_pkg;
  localparam int WORD_W   = 32;
  localparam int SLOT_W   = $clog2(WORD_W);
  localparam int POS_W    = SLOT_W + 1;
  localparam int FRAME_SL = 2 * WORD_W;

  typedef struct packed {
    logic [WORD_W-1:0] lft;
    logic [WORD_W-1:0] rgt;
  } pair_t;

  function automatic logic [POS_W-1:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return POS_W'(16);
      2'd1:    return POS_W'(24);
      default: return POS_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo
  import stereo_ser_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_right,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       pop,
  output pair_t                      head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  pair_t             mem [DEPTH];
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0]     cnt_q, cnt_d;
  logic              push, take;

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign level = cnt_q;
  assign head  = mem[rp_q];
  assign push  = wr_en && wr_right && !full;
  assign take  = pop && !empty;

  always_comb begin
    hold_d = hold_q;
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    if (wr_en && !wr_right) hold_d = wr_data;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (take) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    case ({push, take})
      2'b10:   cnt_d = cnt_q + LW'(1);
      2'b01:   cnt_d = cnt_q - LW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= '{lft: hold_q, rgt: wr_data};
  end
endmodule

// File: rtl/stx_slot_track.sv
module stx_slot_track
  import stereo_ser_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_tick,
  input  logic             cfg_delay,
  output logic [POS_W-1:0] vpos
);
  logic [POS_W-1:0] pos_q, pos_d, pos_now;

  // slot of the current tick, counted from the frame edge
  assign pos_now = frame_tick ? '0 : pos_q;
  // content position: the delayed style lags the frame edge by one slot
  assign vpos    = pos_now - POS_W'(cfg_delay);

  always_comb begin
    pos_d = pos_q;
    if (bit_tick) pos_d = pos_now + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/stx_bit_pick.sv
module stx_bit_pick
  import stereo_ser_tx_pkg::*;
(
  input  pair_t            pair,
  input  logic [POS_W-1:0] vpos,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_rjust,
  output logic             bit_out
);
  logic [WORD_W-1:0] half;
  logic [POS_W-1:0]  wbits, k, idx;

  always_comb begin
    half  = vpos[POS_W-1] ? pair.rgt : pair.lft;
    wbits = wlen_bits(cfg_wlen);
    k     = {1'b0, vpos[SLOT_W-1:0]};
    idx   = '0;
    bit_out = 1'b0;
    if (!cfg_rjust) begin
      if (k < wbits) begin
        idx     = wbits - POS_W'(1) - k;
        bit_out = half[idx[SLOT_W-1:0]];
      end
    end else begin
      if (k >= POS_W'(WORD_W) - wbits) begin
        idx     = {1'b0, ~vpos[SLOT_W-1:0]};
        bit_out = half[idx[SLOT_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stereo_ser_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_tick,
  input  logic                       frame_tick,
  input  logic                       cfg_en,
  input  logic [1:0]                 cfg_wlen,
  input  logic                       cfg_delay,
  input  logic                       cfg_rjust,
  input  logic                       cfg_lvl_sel,
  input  logic                       cfg_uf_ie,
  input  logic                       wr_en,
  input  logic                       wr_right,
  input  logic [31:0]                wr_data,
  input  logic                       uf_clr,
  output logic                       sdata,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       irq_level,
  output logic                       irq_underflow,
  output logic                       underflow_flag
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [POS_W-1:0] vpos;
  logic             vstart, f_empty, pop, pick;
  pair_t            head, cur_q, cur_d, pair_sel;
  logic             act_q, act_d, sd_q, sd_d, uf_q, uf_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  stx_pair_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (wr_en),
    .wr_right (wr_right),
    .wr_data  (wr_data),
    .pop      (pop),
    .head     (head),
    .empty    (f_empty),
    .full     (fifo_full),
    .level    (fifo_level)
  );

  stx_slot_track u_track (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick),
    .cfg_delay  (cfg_delay),
    .vpos       (vpos)
  );

  assign vstart   = bit_tick && (vpos == '0);
  assign pop      = vstart && cfg_en && !f_empty;
  assign pair_sel = vstart ? (f_empty ? '0 : head) : cur_q;

  stx_bit_pick u_pick (
    .pair      (pair_sel),
    .vpos      (vpos),
    .cfg_wlen  (cfg_wlen),
    .cfg_rjust (cfg_rjust),
    .bit_out   (pick)
  );

  always_comb begin
    act_d = act_q;
    cur_d = cur_q;
    sd_d  = sd_q;
    uf_d  = uf_q;
    if (uf_clr) uf_d = 1'b0;
    if (!cfg_en) begin
      act_d = 1'b0;
      sd_d  = 1'b0;
    end else if (bit_tick) begin
      if (vstart) begin
        act_d = 1'b1;
        cur_d = pair_sel;
        if (f_empty) uf_d = 1'b1;
      end
      sd_d = (vstart || act_q) ? pick : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q <= 1'b0;
      cur_q <= '0;
      sd_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      cur_q <= cur_d;
      sd_q  <= sd_d;
      uf_q  <= uf_d;
    end
  end

  assign sdata          = sd_q;
  assign underflow_flag = uf_q;
  assign irq_underflow  = uf_q && cfg_uf_ie;
  assign irq_level      = cfg_lvl_sel ? (fifo_level == '0)
                                      : (fifo_level <= LW'(DEPTH / 2));
endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bit_tick,
  input logic                       cfg_en,
  input logic                       cfg_uf_ie,
  input logic                       wr_en,
  input logic                       wr_right,
  input logic                       uf_clr,
  input logic                       sdata,
  input logic                       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       irq_underflow,
  input logic                       underflow_flag
);
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_right && fifo_full) |=> (fifo_level <= $past(fifo_level)));

  a_r7_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_flag && !uf_clr) |=> underflow_flag);

  a_r8_uf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_underflow |-> (cfg_uf_ie && underflow_flag));

  a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !sdata);

  a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !bit_tick) |=> $stable(sdata));
endmodule

bind stereo_ser_tx stereo_ser_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bit_tick       (bit_tick),
  .cfg_en         (cfg_en),
  .cfg_uf_ie      (cfg_uf_ie),
  .wr_en          (wr_en),
  .wr_right       (wr_right),
  .uf_clr         (uf_clr),
  .sdata          (sdata),
  .fifo_full      (fifo_full),
  .fifo_level     (fifo_level),
  .irq_underflow  (irq_underflow),
  .underflow_flag (underflow_flag)
);

// File: tb/stereo_ser_tx_tb.sv
`timescale 1ns/1ps
module stereo_ser_tx_tb;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, frame_tick = 1'b0;
  logic cfg_en = 1'b0, cfg_delay = 1'b0, cfg_rjust = 1'b0;
  logic cfg_lvl_sel = 1'b0, cfg_uf_ie = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic wr_en = 1'b0, wr_right = 1'b0, uf_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic sdata, fifo_full, irq_level, irq_underflow, underflow_flag;
  logic [LW-1:0] fifo_level;

  int checks = 0, errors = 0;
  logic [63:0] frames [16];
  int nf = 0, last_v = -1, mid_chg = 0;
  logic tick_s = 1'b0, en_s = 1'b0;
  logic [31:0] pl [16];
  logic [31:0] pr [16];

  always #2.5 clk = ~clk;

  stereo_ser_tx #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_tick(frame_tick),
    .cfg_en(cfg_en), .cfg_wlen(cfg_wlen), .cfg_delay(cfg_delay),
    .cfg_rjust(cfg_rjust), .cfg_lvl_sel(cfg_lvl_sel), .cfg_uf_ie(cfg_uf_ie),
    .wr_en(wr_en), .wr_right(wr_right), .wr_data(wr_data), .uf_clr(uf_clr),
    .sdata(sdata), .fifo_full(fifo_full), .fifo_level(fifo_level),
    .irq_level(irq_level), .irq_underflow(irq_underflow),
    .underflow_flag(underflow_flag)
  );

  always @(posedge clk) begin
    tick_s <= bit_tick;
    en_s   <= cfg_en;
  end

  // slot source and frame recorder, indexed by content position
  initial begin : rec
    int bslot, cur_slot, v;
    bit phase;
    logic [63:0] cap;
    logic sd_prev;
    bslot = 0; cur_slot = 0; phase = 0; cap = '0; sd_prev = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (tick_s) begin
        v = (cur_slot - int'(cfg_delay) + 64) % 64;
        cap[63 - v] = sdata;
        last_v = v;
        if (v == 63) begin
          if (nf < 16) frames[nf] = cap;
          nf++;
        end
      end else if (en_s && sdata !== sd_prev) begin
        mid_chg++;
      end
      sd_prev = sdata;
      phase = !phase;
      if (phase) begin
        bit_tick = 1'b1;
        frame_tick = (bslot == 0);
        cur_slot = bslot;
        bslot = (bslot + 1) % 64;
      end else begin
        bit_tick = 1'b0;
        frame_tick = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_half(input logic [31:0] s, input logic [1:0] code, input bit rj);
    int w;
    logic [31:0] m;
    w = (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return rj ? (s & m) : ((s & m) << (32 - w));
  endfunction

  function automatic logic [31:0] gen_l(input int i);
    return 32'hC35A_0F96 ^ (32'(i) * 32'h1F2E_3D4C);
  endfunction

  function automatic logic [31:0] gen_r(input int i);
    logic [31:0] t;
    t = gen_l(i + 7);
    return {t[15:0], t[31:16]} ^ 32'h0F0F_A5A5;
  endfunction

  task automatic put_pair(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk); wr_en = 1'b1; wr_right = 1'b0; wr_data = l;
    @(negedge clk); wr_right = 1'b1; wr_data = r;
    @(negedge clk); wr_en = 1'b0; wr_right = 1'b0;
  endtask

  task automatic wait_v(input int n);
    while (last_v != n) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    while (nf < n) @(negedge clk);
  endtask

  task automatic clear_uf();
    @(negedge clk); uf_clr = 1'b1;
    @(negedge clk); uf_clr = 1'b0;
    @(negedge clk);
    chk("R7 flag cleared", 64'(underflow_flag), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 sdata", 64'(sdata), 64'd0);
    chk("R12 level", 64'(fifo_level), 64'd0);
    chk("R12 full", 64'(fifo_full), 64'd0);
    chk("R12 uf flag", 64'(underflow_flag), 64'd0);
    chk("R12 uf irq", 64'(irq_underflow), 64'd0);
    chk("R12 level irq", 64'(irq_level), 64'd1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      pl[i] = gen_l(i); pr[i] = gen_r(i);
      put_pair(pl[i], pr[i]);
      if (i == DEPTH/2 - 1) chk("R6 half empty at 4", 64'(irq_level), 64'd1);
      if (i == DEPTH/2)     chk("R6 above half at 5", 64'(irq_level), 64'd0);
    end
    chk("R5 level full", 64'(fifo_level), 64'(DEPTH));
    chk("R5 full flag", 64'(fifo_full), 64'd1);
    put_pair(32'hDEAD_BEEF, 32'hFEED_F00D);
    chk("R5 write when full dropped", 64'(fifo_level), 64'(DEPTH));
    cfg_lvl_sel = 1'b1;
    @(negedge clk);
    chk("R6 empty select, not empty", 64'(irq_level), 64'd0);
    cfg_lvl_sel = 1'b0;
  endtask

  // streams n pairs, then expects one zero frame from underflow
  task automatic t_stream(input string req, input logic [1:0] wl, input bit d,
                          input bit rj, input int n, input bit preload,
                          input bit ie, input int seed);
    cfg_en = 1'b0; cfg_wlen = wl; cfg_delay = d; cfg_rjust = rj; cfg_uf_ie = ie;
    if (!preload)
      for (int i = 0; i < n; i++) begin
        pl[i] = gen_l(i + seed); pr[i] = gen_r(i + seed);
        put_pair(pl[i], pr[i]);
      end
    wait_v(40);
    wait_v(41);
    cfg_en = 1'b1;
    nf = 0;
    wait_frames(n + 2);
    for (int i = 0; i < n; i++)
      chk(req, frames[i + 1], {exp_half(pl[i], wl, rj), exp_half(pr[i], wl, rj)});
    chk("R7 zero frame on underflow", frames[n + 1], 64'd0);
    chk("R7 uf flag set", 64'(underflow_flag), 64'd1);
    chk("R8 uf irq gating", 64'(irq_underflow), 64'(ie));
    cfg_en = 1'b0;
    clear_uf();
  endtask

  task automatic t_realign();
    logic [31:0] l, r;
    cfg_wlen = 2'd1; cfg_delay = 1'b0; cfg_rjust = 1'b0;
    l = gen_l(50); r = gen_r(50);
    wait_v(40);
    cfg_en = 1'b1;
    nf = 0;
    wait_frames(2);
    chk("R9 underflow before refill", 64'(underflow_flag), 64'd1);
    wait_v(40);
    put_pair(l, r);
    nf = 0;
    wait_frames(2);
    chk("R9 rest of zero frame", frames[0], 64'd0);
    chk("R9 aligned frame after underflow", frames[1],
        {exp_half(l, 2'd1, 1'b0), exp_half(r, 2'd1, 1'b0)});
    cfg_en = 1'b0;
    clear_uf();
  endtask

  task automatic t_restart();
    cfg_wlen = 2'd2; cfg_delay = 1'b0; cfg_rjust = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pl[i] = gen_l(60 + i); pr[i] = gen_r(60 + i);
      put_pair(pl[i], pr[i]);
    end
    wait_v(40);
    cfg_en = 1'b1;
    nf = 0;
    wait_frames(2);
    chk("R10 first pair before stop", frames[1],
        {exp_half(pl[0], 2'd2, 1'b0), exp_half(pr[0], 2'd2, 1'b0)});
    wait_v(20);
    cfg_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 output low when off", 64'(sdata), 64'd0);
    chk("R10 FIFO kept when off", 64'(fifo_level), 64'd1);
    wait_v(40);
    cfg_en = 1'b1;
    nf = 0;
    wait_frames(2);
    chk("R10 restart with next pair", frames[1],
        {exp_half(pl[2], 2'd2, 1'b0), exp_half(pr[2], 2'd2, 1'b0)});
    cfg_en = 1'b0;
    clear_uf();
  endtask

  initial begin : main
    t_reset();
    t_fill();
    t_stream("R2 R1 16-bit left-justified", 2'd0, 1'b0, 1'b0, DEPTH, 1'b1, 1'b1, 0);
    t_stream("R3 R1 24-bit delayed", 2'd1, 1'b1, 1'b0, 3, 1'b0, 1'b0, 10);
    t_stream("R4 16-bit right-justified", 2'd0, 1'b0, 1'b1, 3, 1'b0, 1'b1, 20);
    t_stream("R3 R1 32-bit delayed", 2'd2, 1'b1, 1'b0, 2, 1'b0, 1'b0, 30);
    t_stream("R1 reserved code as 32-bit right-justified", 2'd3, 1'b0, 1'b1, 2, 1'b0, 1'b0, 40);
    t_realign();
    t_restart();
    chk("R11 no change between bit ticks", 64'(mid_chg), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule